// File: doc/BRIEF.md
# All-Ones Alarm Indication Detector

The block watches a received line bit stream, one bit per strobe, and raises an alarm flag when the stream is all ones or very close to it. Upstream equipment sends an all-ones pattern to show that a fault lies further back along the path. The detector gives a single flag that alarm logic can sample at any time.

Two line modes are supported. In E1 mode the stream is cut into fixed windows of 512 accepted bits. A window with at most two zeros sets the flag, and a window with three or more zeros clears it. In T1 mode the window length comes from an input, given as a number of bit periods. A period of 3 ms to 75 ms is about 4,600 to 116,000 bits. The flag is set when the window reaches 99.9 % ones density and cleared when it does not. Windows never overlap, and the flag only moves at the end of a window. Decoding, framing and register access are handled elsewhere.

Top module: `aisDetector`

## Requirements
- R1: While reset is asserted and after it is released, `aisFlag` is 0 until a window completes with the set condition.
- R2: In E1 mode (`modeT1` = 0) the stream is split into consecutive, non-overlapping windows of 512 accepted bits, and `aisFlag` is updated on the clock edge that accepts the 512th bit of each window.
- R3: In E1 mode, a window holding 0, 1 or 2 zero bits (`bitIn` = 0) leaves `aisFlag` at 1 after its last bit.
- R4: In E1 mode, a window holding 3 or more zero bits leaves `aisFlag` at 0 after its last bit.
- R5: In T1 mode (`modeT1` = 1) a window is `t1Period` accepted bits long. The allowed zero count is `t1Period` divided by 1000 and rounded down. A window whose zero count does not exceed this allowance sets `aisFlag` to 1 on its last bit.
- R6: In T1 mode, a window whose zero count exceeds the allowance sets `aisFlag` to 0 on its last bit.
- R7: A bit presented while `bitValid` is 0 is neither counted as a bit nor as a zero.
- R8: A change of `modeT1` forces `aisFlag` to 0 on the next clock edge and discards the partial window. The next window begins with the next accepted bit.
- R9: Between window ends, `aisFlag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Strobe: `bitIn` carries a line bit this cycle |
| bitIn | input | 1 | Received bit, 1 = mark |
| modeT1 | input | 1 | 0 = E1 window rules, 1 = T1 window rules |
| t1Period | input | PERIOD_W (18) | T1 window length in bit periods |
| aisFlag | output | 1 | Alarm indication, 1 = all-ones stream detected |

## Verification
The hardest situation to reach is a window edge that does not line up with the bench's own idea of where windows start. This happens after a mode change that arrives partway through a window, or when invalid cycles carrying zeros are mixed into a window. The stimulus covers both cases. It switches mode after 300 bits of an unfinished T1 window and then checks the flag both one bit before and exactly at the 512th bit that follows. It also pads a whole E1 window with idle cycles that carry zero bits. For both T1 thresholds, periods of 999 and 2500 bits place the zero count exactly at the allowance and exactly one above it.

// File: rtl/aisPkg.sv
package aisPkg;
  // Strobes sent from the control module to the datapath counters
  typedef struct packed {
    logic windowEnd;  // accepted bit is the last one of the current window
    logic restart;    // mode changed: drop partial window
  } aisCtrlT;
endpackage

// File: rtl/aisDatapath.sv
module aisDatapath
  import aisPkg::*;
#(
  parameter int PERIOD_W    = 18,
  parameter int DENSITY_DIV = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                bitIn,
  input  aisCtrlT             ctrl,
  output logic [PERIOD_W-1:0] bitCnt,
  output logic [PERIOD_W-1:0] zeroNext,
  output logic [PERIOD_W-1:0] allowNext
);
  localparam int SUB_W = $clog2(DENSITY_DIV);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(DENSITY_DIV - 1);

  logic [PERIOD_W-1:0] zeroCnt;
  logic [PERIOD_W-1:0] allowCnt;
  logic [SUB_W-1:0]    subCnt;
  logic                subWrap;

  assign subWrap   = (subCnt == SUB_LAST);
  assign zeroNext  = zeroCnt + PERIOD_W'(bitValid && !bitIn);
  assign allowNext = allowCnt + PERIOD_W'(bitValid && subWrap);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.restart) begin
      bitCnt   <= '0;
      zeroCnt  <= '0;
      allowCnt <= '0;
      subCnt   <= '0;
    end else if (bitValid) begin
      if (ctrl.windowEnd) begin
        bitCnt   <= '0;
        zeroCnt  <= '0;
        allowCnt <= '0;
        subCnt   <= '0;
      end else begin
        bitCnt   <= bitCnt + 1'b1;
        zeroCnt  <= zeroNext;
        allowCnt <= allowNext;
        subCnt   <= subWrap ? '0 : subCnt + 1'b1;
      end
    end
  end

  // R7: zeros in the current window never exceed bits accepted so far
  p_zero_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    zeroCnt <= bitCnt);

  // R7: an idle cycle leaves the bit position untouched
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !ctrl.restart) |=> $stable(bitCnt));
endmodule

// File: rtl/aisControl.sv
module aisControl
  import aisPkg::*;
#(
  parameter int PERIOD_W     = 18,
  parameter int E1_WIN       = 512,
  parameter int E1_MAX_ZEROS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                modeT1,
  input  logic [PERIOD_W-1:0] t1Period,
  input  logic [PERIOD_W-1:0] bitCnt,
  input  logic [PERIOD_W-1:0] zeroNext,
  input  logic [PERIOD_W-1:0] allowNext,
  output aisCtrlT             ctrl,
  output logic                aisFlag
);
  localparam logic [PERIOD_W-1:0] E1_LEN   = PERIOD_W'(E1_WIN);
  localparam logic [PERIOD_W-1:0] E1_ALLOW = PERIOD_W'(E1_MAX_ZEROS);

  logic                modeQ;
  logic [PERIOD_W-1:0] winLen;
  logic [PERIOD_W-1:0] allowed;
  logic [PERIOD_W:0]   posNext;

  assign winLen  = modeT1 ? t1Period : E1_LEN;
  assign allowed = modeT1 ? allowNext : E1_ALLOW;
  assign posNext = {1'b0, bitCnt} + 1'b1;

  always_comb begin
    ctrl.restart   = (modeT1 != modeQ);
    ctrl.windowEnd = bitValid && !ctrl.restart && (posNext >= {1'b0, winLen});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      aisFlag <= 1'b0;
    end else begin
      modeQ <= modeT1;
      if (ctrl.restart)        aisFlag <= 1'b0;
      else if (ctrl.windowEnd) aisFlag <= (zeroNext <= allowed);
    end
  end

  // R9: flag moves only at a window end or a restart
  p_hold_between_windows_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.windowEnd && !ctrl.restart) |=> $stable(aisFlag));

  // R8: a mode change at the port clears the flag next cycle
  p_mode_change_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeT1 != $past(modeT1)) |=> !aisFlag);

  // R2: an E1 window always ends on its 512th bit
  p_e1_window_length_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.windowEnd && !modeT1) |-> (bitCnt == E1_LEN - 1'b1));
endmodule

// File: rtl/aisDetector.sv
module aisDetector
  import aisPkg::*;
#(
  parameter int PERIOD_W     = 18,
  parameter int E1_WIN       = 512,
  parameter int E1_MAX_ZEROS = 2,
  parameter int DENSITY_DIV  = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                bitIn,
  input  logic                modeT1,
  input  logic [PERIOD_W-1:0] t1Period,
  output logic                aisFlag
);
  aisCtrlT             ctrl;
  logic [PERIOD_W-1:0] bitCnt;
  logic [PERIOD_W-1:0] zeroNext;
  logic [PERIOD_W-1:0] allowNext;

  aisDatapath #(.PERIOD_W(PERIOD_W), .DENSITY_DIV(DENSITY_DIV)) dp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn), .ctrl(ctrl),
    .bitCnt(bitCnt), .zeroNext(zeroNext), .allowNext(allowNext)
  );

  aisControl #(.PERIOD_W(PERIOD_W), .E1_WIN(E1_WIN), .E1_MAX_ZEROS(E1_MAX_ZEROS)) ctl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .modeT1(modeT1), .t1Period(t1Period),
    .bitCnt(bitCnt), .zeroNext(zeroNext), .allowNext(allowNext),
    .ctrl(ctrl), .aisFlag(aisFlag)
  );
endmodule

// File: tb/aisDetector_test.sv
`timescale 1ns/1ps
module aisDetector_test;
  localparam int PW = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bitValid = 1'b0;
  logic          bitIn = 1'b1;
  logic          modeT1 = 1'b0;
  logic [PW-1:0] t1Period = PW'(2500);
  logic          aisFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic  expVal;
    string req;
  } expItemT;
  expItemT expQ[$];

  always #5 clk = ~clk;

  aisDetector uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .modeT1(modeT1), .t1Period(t1Period), .aisFlag(aisFlag)
  );

  // Monitor: pops each expectation and compares with the port value
  initial begin
    forever begin
      wait (expQ.size() > 0);
      #1;
      begin
        expItemT it;
        it = expQ.pop_front();
        checks++;
        if (aisFlag !== it.expVal) begin
          errors++;
          $display("FAIL %s aisFlag actual %b expected %b", it.req, aisFlag, it.expVal);
        end
      end
    end
  end

  task automatic expectFlag(input logic v, input string req);
    expItemT it;
    it.expVal = v;
    it.req = req;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // Send n accepted bits; nz of them are zeros at positions 5,15,25,...
  // gap > 0 inserts that many idle cycles with bitIn = 0 before each bit.
  task automatic sendBits(input int n, input int nz, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        bitValid = 1'b0;
        bitIn = 1'b0;
      end
      @(negedge clk);
      bitValid = 1'b1;
      bitIn = ((i % 10) == 5 && (i / 10) < nz) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    bitValid = 1'b0;
    bitIn = 1'b1;
  endtask

  task automatic changeMode(input logic m);
    @(negedge clk);
    modeT1 = m;
    @(negedge clk);
  endtask

  initial begin
    int thr;
    repeat (3) @(negedge clk);
    expectFlag(1'b0, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    expectFlag(1'b0, "R1 after reset");

    // E1 windows
    sendBits(511, 0, 0);
    expectFlag(1'b0, "R2 before 512th bit");
    sendBits(1, 0, 0);
    expectFlag(1'b1, "R3 all ones window");
    sendBits(512, 2, 0);
    expectFlag(1'b1, "R3 two zeros");
    sendBits(300, 3, 0);
    expectFlag(1'b1, "R9 held mid window");
    sendBits(212, 0, 0);
    expectFlag(1'b0, "R4 three zeros");
    sendBits(512, 1, 0);
    expectFlag(1'b1, "R3 one zero");
    sendBits(512, 40, 0);
    expectFlag(1'b0, "R4 many zeros");
    sendBits(511, 0, 2);
    expectFlag(1'b0, "R7 idle zeros not counted as bits");
    sendBits(1, 0, 0);
    expectFlag(1'b1, "R7 idle zeros ignored");

    // Switch to T1 while flag is set
    changeMode(1'b1);
    expectFlag(1'b0, "R8 mode change clears flag");

    t1Period = PW'(2500);
    thr = 2500 / 1000;
    sendBits(2500, thr, 0);
    expectFlag(1'b1, "R5 zeros at allowance");
    sendBits(2500, thr + 1, 0);
    expectFlag(1'b0, "R6 zeros above allowance");
    sendBits(2499, 0, 0);
    expectFlag(1'b0, "R9 held before T1 window end");
    sendBits(1, 0, 0);
    expectFlag(1'b1, "R5 all ones T1");

    t1Period = PW'(999);
    thr = 999 / 1000;
    sendBits(999, 1, 0);
    expectFlag(1'b0, "R6 zero allowance one zero");
    sendBits(999, thr, 0);
    expectFlag(1'b1, "R5 zero allowance no zeros");

    // Partial T1 window then back to E1
    sendBits(300, 0, 0);
    changeMode(1'b0);
    expectFlag(1'b0, "R8 return to E1 clears flag");
    sendBits(511, 0, 0);
    expectFlag(1'b0, "R8 window restarted");
    sendBits(1, 0, 0);
    expectFlag(1'b1, "R8 first E1 window after change");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule